// File: doc/BRIEF.md
# Interrupt Line Routing Crossbar

This block builds the 128-line interrupt request vector that feeds a processor's interrupt controller. Two bands of the vector, lines 0 to 31 and lines 96 to 127, are wired directly to interrupt sources inside the processor subsystem. No selector exists for those lines and software cannot alter them. The middle band, lines 32 to 95, is remappable. Each line in that band has its own selector, which picks one request from a pool of 420 device interrupt inputs.

The selectors are held in 32 configuration words, one word for each adjacent even/odd pair of lines. Software reads and writes these words through a single-cycle register port. Each selector comes out of reset pointing at its own instance number, so the routing works with no software set-up at all. Every line of the output vector is registered.

Top module: `xbar_irq_route`

## Requirements
- R1: While reset is asserted, `irq_o` is all zero. After reset, word p (0 to 31) reads back the value 2p+1 in bits [8:0] and the value 2p+2 in bits [24:16].
- R2: Output lines 0 to 31 equal `int_irq_i[31:0]`, and output lines 96 to 127 equal `int_irq_i[63:32]`. Each appears one clock after the input.
- R3: Remappable line 32+j (j = 0 to 63) is driven by selector j. When the selector value s lies in 1 to 420, the line shows `dev_irq_i[s-1]` one clock later.
- R4: A write is accepted when `cfg_valid_i` and `cfg_we_i` are both high. An accepted write to word p loads `cfg_wdata_i[8:0]` into the selector of line 32+2p and loads `cfg_wdata_i[24:16]` into the selector of line 33+2p. Read data is combinational and always shows the word at `cfg_addr_i`.
- R5: Bits [15:9] and [31:25] of every word read as zero and ignore written values. A cycle with `cfg_valid_i` or `cfg_we_i` low changes no selector.
- R6: A selector value of 0, or any value above 420, drives its output line low.
- R7: A selector write accepted at clock edge T governs the routed output registered at edge T+1. The output registered at edge T still uses the old selector value.
- R8: No write, at any address or with any data, alters lines 0 to 31 or lines 96 to 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_irq_i | input | 64 | Internal sources. Bits [31:0] feed lines 0 to 31 and bits [63:32] feed lines 96 to 127 |
| dev_irq_i | input | 420 | Device interrupt pool. Bit k-1 is device input k |
| cfg_valid_i | input | 1 | Register access valid |
| cfg_we_i | input | 1 | Register write enable. Writes the full word |
| cfg_addr_i | input | 5 | Word index, which is the line pair index |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Combinational read data |
| irq_o | output | 128 | Registered interrupt vector |

## Verification
Every output line is due exactly one clock after the device or internal input values that produce it. Read data is due in the same cycle that the address is presented, and it shows the effect of a write as soon as the accepting edge has passed. A routed line shows a new selector one edge later still.

The bench computes each cycle's expected vector from the inputs it drives and from its own copy of the selector state, taken before that cycle's write is applied. It then compares `irq_o` and `cfg_rdata_o` one time unit after the next rising edge. This keeps every check aligned with the register stages.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    parameter int NUM_LINES  = 128;
    parameter int REMAP_BASE = 32;
    parameter int REMAP_CNT  = 64;
    parameter int NUM_DEV    = 420;
    parameter int SEL_W      = 9;
    parameter int DATA_W     = 32;
    parameter int ODD_LSB    = 16;
endpackage

// File: rtl/xbar_line_pick.sv
module xbar_line_pick #(
    parameter int NUM_DEV = xbar_pkg::NUM_DEV,
    parameter int SEL_W   = xbar_pkg::SEL_W
) (
    input  logic [NUM_DEV-1:0] dev_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               hit_o
);
    localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(NUM_DEV);

    logic [SEL_W-1:0] idx;

    always_comb begin
        idx   = sel_i - 1'b1;
        hit_o = 1'b0;
        // select 0 and values past the pool are "no source"
        if (sel_i != '0 && sel_i <= MAX_SEL) begin
            hit_o = dev_i[idx];
        end
    end
endmodule

// File: rtl/xbar_sel_bank.sv
module xbar_sel_bank #(
    parameter int PAIR_CNT = xbar_pkg::REMAP_CNT / 2,
    parameter int SEL_W    = xbar_pkg::SEL_W,
    parameter int DATA_W   = xbar_pkg::DATA_W,
    parameter int ODD_LSB  = xbar_pkg::ODD_LSB,
    parameter int ADDR_W   = $clog2(PAIR_CNT)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                valid_i,
    input  logic                                we_i,
    input  logic [ADDR_W-1:0]                   addr_i,
    input  logic [DATA_W-1:0]                   wdata_i,
    output logic [DATA_W-1:0]                   rdata_o,
    output logic [2*PAIR_CNT-1:0][SEL_W-1:0]    sel_o
);
    localparam int LINE_CNT = 2 * PAIR_CNT;

    typedef struct packed {
        logic [LINE_CNT-1:0][SEL_W-1:0] sel;
    } bank_t;

    bank_t st_d, st_q;
    logic [ADDR_W:0] even_idx, odd_idx;

    always_comb begin
        even_idx = {addr_i, 1'b0};
        odd_idx  = {addr_i, 1'b1};
        st_d     = st_q;
        if (valid_i && we_i) begin
            st_d.sel[even_idx] = wdata_i[SEL_W-1:0];
            st_d.sel[odd_idx]  = wdata_i[ODD_LSB +: SEL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            // each selector starts at its own instance number
            for (int k = 0; k < LINE_CNT; k++) begin
                st_q.sel[k] <= SEL_W'(k + 1);
            end
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o                     = '0;
        rdata_o[SEL_W-1:0]          = st_q.sel[even_idx];
        rdata_o[ODD_LSB +: SEL_W]   = st_q.sel[odd_idx];
    end

    assign sel_o = st_q.sel;

    p_wr_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && we_i) |=> st_q.sel[{$past(addr_i), 1'b0}] == $past(wdata_i[SEL_W-1:0]));

    p_wr_odd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && we_i) |=> st_q.sel[{$past(addr_i), 1'b1}] == $past(wdata_i[ODD_LSB +: SEL_W]));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && we_i) |=> $stable(st_q.sel));
endmodule

// File: rtl/xbar_irq_route.sv
module xbar_irq_route #(
    parameter int NUM_LINES  = xbar_pkg::NUM_LINES,
    parameter int REMAP_BASE = xbar_pkg::REMAP_BASE,
    parameter int REMAP_CNT  = xbar_pkg::REMAP_CNT,
    parameter int NUM_DEV    = xbar_pkg::NUM_DEV,
    parameter int SEL_W      = xbar_pkg::SEL_W,
    parameter int DATA_W     = xbar_pkg::DATA_W,
    parameter int ODD_LSB    = xbar_pkg::ODD_LSB,
    parameter int FIXED_CNT  = NUM_LINES - REMAP_CNT,
    parameter int ADDR_W     = $clog2(REMAP_CNT / 2)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FIXED_CNT-1:0]  int_irq_i,
    input  logic [NUM_DEV-1:0]    dev_irq_i,
    input  logic                  cfg_valid_i,
    input  logic                  cfg_we_i,
    input  logic [ADDR_W-1:0]     cfg_addr_i,
    input  logic [DATA_W-1:0]     cfg_wdata_i,
    output logic [DATA_W-1:0]     cfg_rdata_o,
    output logic [NUM_LINES-1:0]  irq_o
);
    localparam int PAIR_CNT = REMAP_CNT / 2;
    localparam int HI_BASE  = REMAP_BASE + REMAP_CNT;
    localparam int HI_CNT   = NUM_LINES - HI_BASE;
    localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(NUM_DEV);

    typedef struct packed {
        logic [NUM_LINES-1:0] irq;
        logic                 up;
    } out_t;

    out_t st_d, st_q;
    logic [REMAP_CNT-1:0][SEL_W-1:0] sel;
    logic [REMAP_CNT-1:0]            picked;
    logic [NUM_LINES-1:0]            merged;

    xbar_sel_bank #(
        .PAIR_CNT (PAIR_CNT),
        .SEL_W    (SEL_W),
        .DATA_W   (DATA_W),
        .ODD_LSB  (ODD_LSB),
        .ADDR_W   (ADDR_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (cfg_valid_i),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .rdata_o (cfg_rdata_o),
        .sel_o   (sel)
    );

    for (genvar j = 0; j < REMAP_CNT; j++) begin : g_remap
        xbar_line_pick #(
            .NUM_DEV (NUM_DEV),
            .SEL_W   (SEL_W)
        ) u_pick (
            .dev_i (dev_irq_i),
            .sel_i (sel[j]),
            .hit_o (picked[j])
        );
        assign merged[REMAP_BASE + j] = picked[j];

        p_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[j] == '0 || sel[j] > MAX_SEL) |=> !irq_o[REMAP_BASE + j]);
    end

    for (genvar i = 0; i < REMAP_BASE; i++) begin : g_fix_lo
        assign merged[i] = int_irq_i[i];
    end

    for (genvar i = 0; i < HI_CNT; i++) begin : g_fix_hi
        assign merged[HI_BASE + i] = int_irq_i[REMAP_BASE + i];
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = merged;
        st_d.up  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    p_fixed_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.up |-> irq_o[REMAP_BASE-1:0] == $past(int_irq_i[REMAP_BASE-1:0]));

    p_fixed_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.up |-> irq_o[NUM_LINES-1:HI_BASE] == $past(int_irq_i[FIXED_CNT-1:REMAP_BASE]));

    p_reset_r1: assert property (@(posedge clk) !rst_n |-> irq_o == '0);
endmodule

// File: tb/xbar_irq_route_bench.sv
`timescale 1ns/100ps
module xbar_irq_route_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  int_v = '0;
    logic [419:0] dev_v = '0;
    logic         cv = 1'b0, cw = 1'b0;
    logic [4:0]   ca = '0;
    logic [31:0]  cd = '0;
    logic [31:0]  rdata;
    logic [127:0] irq;

    int total = 0, bad = 0;
    bit done = 1'b0;
    logic [8:0] sel_m [64];

    always #2.5 clk = ~clk;

    xbar_irq_route u_xbar_irq_route (
        .clk (clk), .rst_n (rst_n), .int_irq_i (int_v), .dev_irq_i (dev_v),
        .cfg_valid_i (cv), .cfg_we_i (cw), .cfg_addr_i (ca), .cfg_wdata_i (cd),
        .cfg_rdata_o (rdata), .irq_o (irq)
    );

    function automatic logic [127:0] exp_irq();
        logic [127:0] e;
        for (int i = 0; i < 128; i++) begin
            if (i < 32) e[i] = int_v[i];
            else if (i >= 96) e[i] = int_v[i - 64];
            else begin
                int s = int'(sel_m[i - 32]);
                e[i] = (s >= 1 && s <= 420) ? dev_v[s - 1] : 1'b0;
            end
        end
        return e;
    endfunction

    function automatic logic [31:0] exp_word(input int p);
        return {7'b0, sel_m[2*p + 1], 7'b0, sel_m[2*p]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rand_inputs();
        int_v = {$urandom, $urandom};
        for (int k = 0; k < 420; k++) dev_v[k] = $urandom_range(0, 1) == 1;
    endtask

    // one clock: drive, predict, advance, compare
    task automatic cycle(input bit v, input bit w, input logic [4:0] a, input logic [31:0] d);
        logic [127:0] e;
        cv = v; cw = w; ca = a; cd = d;
        e = exp_irq();
        if (v && w) begin
            sel_m[2*a]     = d[8:0];
            sel_m[2*a + 1] = d[24:16];
        end
        @(posedge clk); #1;
        chk(irq[31:0] == e[31:0] && irq[127:96] == e[127:96], "R2/R8 fixed lines",
            irq, e);
        chk(irq[95:32] == e[95:32], "R3/R6/R7 routed lines", irq, e);
        chk(rdata == exp_word(int'(a)), "R4/R5 read data", 128'(rdata), 128'(exp_word(int'(a))));
        cv = 1'b0; cw = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int j = 0; j < 64; j++) sel_m[j] = 9'(j + 1);
        int_v = {$urandom, $urandom};
        dev_v = '1;
        repeat (3) @(posedge clk);
        #1;
        chk(irq == '0, "R1 irq under reset", irq, '0);
        rst_n = 1'b1;
        #1;
        // R1: default selector values
        for (int p = 0; p < 32; p++) begin
            ca = 5'(p); #1;
            chk(rdata == exp_word(p) && rdata[8:0] == 9'(2*p + 1), "R1 reset word",
                128'(rdata), 128'(exp_word(p)));
        end
        int_v = '0; dev_v = '0;
        cycle(0, 0, 0, 0);

        // R6: 0 and 421 give no source even with all devices high
        dev_v = '1;
        cycle(1, 1, 5'd0, {7'b0, 9'd421, 7'b0, 9'd0});
        cycle(0, 0, 5'd0, 0);
        chk(irq[33:32] == 2'b00 && irq[34] == 1'b1, "R6 off selectors",
            128'(irq[34:32]), 128'(3'b100));

        // R5: reserved bits, and valid or we alone
        cycle(1, 1, 5'd1, 32'hFFFF_FFFF);
        chk(rdata == 32'h01FF_01FF, "R5 reserved bits read zero", 128'(rdata), 128'h01FF01FF);
        cycle(1, 0, 5'd1, 32'h0003_0002);
        cycle(0, 1, 5'd1, 32'h0003_0002);
        chk(rdata == 32'h01FF_01FF, "R5 no write without valid and we", 128'(rdata), 128'h01FF01FF);

        // R7: new selector shows one edge after the accepting edge
        dev_v = '0; dev_v[9] = 1'b1;
        cycle(0, 0, 5'd2, 0);
        cycle(1, 1, 5'd2, {7'b0, 9'd6, 7'b0, 9'd10});
        chk(irq[36] == 1'b0, "R7 old selector at accepting edge", 128'(irq[36]), 128'd0);
        cycle(0, 0, 5'd2, 0);
        chk(irq[36] == 1'b1, "R7 new selector one edge later", 128'(irq[36]), 128'd1);

        // R3: top of the pool
        dev_v = '0; dev_v[419] = 1'b1;
        cycle(1, 1, 5'd31, {7'b0, 9'd420, 7'b0, 9'd1});
        cycle(0, 0, 5'd31, 0);
        chk(irq[95] == 1'b1 && irq[94] == 1'b0, "R3 select 420", 128'(irq[95:94]), 128'd2);

        // random traffic, R8 fixed lines held under writes
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] d;
            rand_inputs();
            d = $urandom;
            if ($urandom_range(0, 3) == 0) begin
                d[8:0]   = 9'($urandom_range(0, 440));
                d[24:16] = 9'($urandom_range(0, 440));
            end
            cycle($urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1,
                  5'($urandom_range(0, 31)), d);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule